// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block lets a small processor core reach external memory over sixteen shared address/data pins. The core hands it one request at a time: a 21-bit address, two byte enables, write data, and flags saying whether the access is a write and whether it is an instruction fetch. The controller runs a fixed bus cycle. First comes an address phase, where the low sixteen address bits sit on the shared pins and ALE is high. Then comes a strobe phase, where the read or write strobe is active and data moves. Last comes a single recovery cycle. It drives the byte-lane strobes and the high-byte enable from the byte enables. It raises INST for fetches.

The strobe phase lasts one cycle plus a programmed wait count. It is stretched further for as long as the READY input is low once that count has run out. An external master may claim the bus with an active-low hold request. The controller grants it only between cycles. While the bus is granted, the controller releases all pins and flags any internal request that is waiting. When no cycle is running and the bus is not granted, the shared pins carry a general-purpose port value and enable. Pads are modelled as an output value plus an output enable.

Top module: `ext_bus_ctrl`

## Requirements
- R1: With no cycle running and no hold granted, `ad_out`/`ad_oe` equal `gpio_out`/`gpio_oe`, `ale` is 0, and `rd_n`, `wr_n`, `wrl_n`, `wrh_n`, `bhe_n` are 1. `rsp_valid` is 0. The same values hold after reset.
- R2: `req_ready` is 1 only when no cycle is running, no hold is granted and `hold_n` is 1. The cycle after a request is accepted is the address phase: `ale`=1, `ad_out`=addr[15:0], `ad_oe`=all ones, `a_hi`=addr[20:16], and both read and write strobes are high.
- R3: The strobe phase follows the address phase. `rd_n` is 0 only for reads and `wr_n` is 0 only for writes. With READY high, it lasts `ws_count`+1 cycles, using the `ws_count` value sampled during the address phase.
- R4: The strobe phase ends at the first strobe cycle in which the wait count has expired and `ready` is 1. When `ready` is low for the first N strobe cycles, the phase lasts max(`ws_count`, N)+1 cycles.
- R5: During a write strobe, `wrl_n` is 0 when `req_be[0]`=1 and `wrh_n` is 0 when `req_be[1]`=1. Both stay 1 on reads and outside the strobe phase.
- R6: `bhe_n` is 0 during the address and strobe phases when `req_be[1]`=1, and 1 otherwise.
- R7: `inst` equals the fetch flag of the request through the address, strobe and recovery cycles, and is 0 outside a cycle.
- R8: On a read, `ad_oe` is all zeros in the strobe phase. `ad_in` is captured on the last strobe cycle. `rsp_valid` is 1 for exactly the recovery cycle, with `rsp_rdata` equal to the captured value.
- R9: On a write, `ad_out`=write data and `ad_oe`=all ones during the strobe phase. `rsp_valid` is 1 in the recovery cycle.
- R10: The recovery cycle is exactly one cycle long. All strobes are high and `ad_oe` is all zeros. The following cycle is idle.
- R11: `hold_n` low, sampled at an edge while idle, gives `hlda_n`=0 from the next cycle. While granted, `ad_oe` is zero, strobes are high and `ale` is 0. A hold requested during a cycle takes effect only after the cycle returns to idle.
- R12: `breq_n` is 0 exactly when a hold is granted and `req_valid` is 1. No request is accepted while a hold is granted.
- R13: When `hold_n` is 1 at an edge while granted, `hlda_n` returns to 1 in the next cycle, and requests are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 16 | Write data |
| ws_count | input | 4 | Programmed wait states |
| ready | input | 1 | Active-high ready from memory |
| rsp_valid | output | 1 | Cycle finished (recovery cycle) |
| rsp_rdata | output | 16 | Last read data |
| gpio_out | input | 16 | Port value for idle AD pins |
| gpio_oe | input | 16 | Port enable for idle AD pins |
| ad_in | input | 16 | AD pad input |
| ad_out | output | 16 | AD pad output value |
| ad_oe | output | 16 | AD pad output enable |
| a_hi | output | 5 | Address bits 20:16 during a cycle |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| wrl_n | output | 1 | Low-byte write strobe, active low |
| wrh_n | output | 1 | High-byte write strobe, active low |
| bhe_n | output | 1 | High-byte enable, active low |
| inst | output | 1 | Instruction fetch cycle |
| hold_n | input | 1 | External bus request, active low |
| hlda_n | output | 1 | Bus granted, active low |
| breq_n | output | 1 | Internal request pending during hold, active low |

## Verification
The hardest case to reach is a hold request that arrives while a cycle is in its strobe phase. There the grant must wait through the strobe and recovery cycles and one idle cycle before it appears. Meanwhile a new request that is raised during the grant must be refused while BREQ# is reported. The bench drives the hold request at the first strobe cycle of a read that has programmed waits. It then keeps the request valid through the granted period and releases the hold before letting the request through. Capture timing is exercised by putting the expected read value on the pads only in the final strobe cycle, so capturing one cycle early or late is visible. Random cycles mix wait counts with READY held low for random stretches.

// File: rtl/ebc_pkg.sv
// Shared widths and types for the multiplexed external bus controller.
// Assumes a 16-bit shared address/data bus with two byte lanes.
package ebc_pkg;
    parameter int EBC_ADDR_W = 21;
    parameter int EBC_DATA_W = 16;
    localparam int EBC_BE_W  = EBC_DATA_W / 8;
    localparam int EBC_HI_W  = EBC_ADDR_W - EBC_DATA_W;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ADDR  = 2'd1,
        PH_STRB  = 2'd2,
        PH_RECOV = 2'd3
    } ebc_phase_e;

    typedef struct packed {
        logic                  write;
        logic                  fetch;
        logic [EBC_BE_W-1:0]   be;
        logic [EBC_ADDR_W-1:0] addr;
        logic [EBC_DATA_W-1:0] wdata;
    } ebc_req_t;
endpackage

// File: rtl/ebc_cycle_fsm.sv
// Bus cycle sequencer: idle, address, strobe (with wait states), recovery.
// Assumes 'start' is already qualified by idle and hold state; the wait
// count is sampled in the address phase; read data is captured on the
// final strobe cycle.
module ebc_cycle_fsm
    import ebc_pkg::*;
#(
    parameter int WS_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  ebc_req_t              req_in,
    input  logic [WS_W-1:0]       ws_count,
    input  logic                  ready,
    input  logic [EBC_DATA_W-1:0] ad_in,
    output ebc_phase_e            phase,
    output ebc_req_t              cur_req,
    output logic [EBC_DATA_W-1:0] rdata
);
    logic [WS_W-1:0] wait_cnt;

    // Advance the cycle phase, count wait states and capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            wait_cnt <= '0;
            cur_req  <= '0;
            rdata    <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        cur_req <= req_in;
                        phase   <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    wait_cnt <= ws_count;
                    phase    <= PH_STRB;
                end
                PH_STRB: begin
                    if (wait_cnt != '0) begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end else if (ready) begin
                        if (!cur_req.write) rdata <= ad_in;
                        phase <= PH_RECOV;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2
    addr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_ADDR |=> phase == PH_STRB);
    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STRB && wait_cnt != '0) |=> phase == PH_STRB);
    // R4
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STRB && !ready) |=> phase == PH_STRB);
    // R10
    recov_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_RECOV |=> phase == PH_IDLE);
endmodule

// File: rtl/ebc_hold_arb.sv
// Hold/acknowledge arbiter: grants the bus to an external master only
// while no cycle is running and reports pending internal requests.
// Assumes hold_n is already synchronous to clk.
module ebc_hold_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_idle,
    input  logic hold_n,
    input  logic req_valid,
    output logic held,
    output logic hlda_n,
    output logic breq_n
);
    // Enter the granted state from idle, leave when the request drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (!held && bus_idle && !hold_n) begin
            held <= 1'b1;
        end else if (held && hold_n) begin
            held <= 1'b0;
        end
    end

    // Drive the acknowledge and pending-request pins.
    always_comb begin
        hlda_n = !held;
        breq_n = !(held && req_valid);
    end

    // R11
    grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $past(bus_idle));
    // R13
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && hold_n) |=> !held);
endmodule

// File: rtl/ebc_pad_mux.sv
// Pin decoder: turns the cycle phase, the latched request and the hold
// state into pad values, enables and bus strobes. Purely combinational;
// the clock and reset serve only the embedded checks.
module ebc_pad_mux
    import ebc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  ebc_phase_e            phase,
    input  logic                  held,
    input  ebc_req_t              cur_req,
    input  logic [EBC_DATA_W-1:0] gpio_out,
    input  logic [EBC_DATA_W-1:0] gpio_oe,
    output logic [EBC_DATA_W-1:0] ad_out,
    output logic [EBC_DATA_W-1:0] ad_oe,
    output logic [EBC_HI_W-1:0]   a_hi,
    output logic                  ale,
    output logic                  rd_n,
    output logic                  wr_n,
    output logic                  wrl_n,
    output logic                  wrh_n,
    output logic                  bhe_n,
    output logic                  inst
);
    // Decode all pins from the current phase.
    always_comb begin
        ad_out = gpio_out;
        ad_oe  = held ? '0 : gpio_oe;
        a_hi   = '0;
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        wrl_n  = 1'b1;
        wrh_n  = 1'b1;
        bhe_n  = 1'b1;
        inst   = 1'b0;
        case (phase)
            PH_ADDR: begin
                ad_out = cur_req.addr[EBC_DATA_W-1:0];
                ad_oe  = '1;
                a_hi   = cur_req.addr[EBC_ADDR_W-1:EBC_DATA_W];
                ale    = 1'b1;
                bhe_n  = !cur_req.be[1];
                inst   = cur_req.fetch;
            end
            PH_STRB: begin
                a_hi   = cur_req.addr[EBC_ADDR_W-1:EBC_DATA_W];
                ad_out = cur_req.wdata;
                ad_oe  = cur_req.write ? '1 : '0;
                rd_n   = cur_req.write;
                wr_n   = !cur_req.write;
                wrl_n  = !(cur_req.write && cur_req.be[0]);
                wrh_n  = !(cur_req.write && cur_req.be[1]);
                bhe_n  = !cur_req.be[1];
                inst   = cur_req.fetch;
            end
            PH_RECOV: begin
                a_hi   = cur_req.addr[EBC_ADDR_W-1:EBC_DATA_W];
                ad_out = cur_req.wdata;
                ad_oe  = '0;
                inst   = cur_req.fetch;
            end
            default: ;
        endcase
    end

    // R11
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> (ad_oe == '0 && rd_n && wr_n && !ale));
    // R2
    ale_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!rd_n || !wr_n));
    // R5
    byte_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrl_n || !wrh_n) |-> !wr_n);
    // R7
    inst_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(inst));
endmodule

// File: rtl/ext_bus_ctrl.sv
// Multiplexed external bus controller top: accepts one core request at a
// time, runs an address/strobe/recovery cycle on shared AD pins, and
// hands the bus to an external master between cycles.
// Assumes synchronous inputs and a single outstanding request.
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int WS_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic                  req_fetch,
    input  logic [EBC_BE_W-1:0]   req_be,
    input  logic [EBC_ADDR_W-1:0] req_addr,
    input  logic [EBC_DATA_W-1:0] req_wdata,
    input  logic [WS_W-1:0]       ws_count,
    input  logic                  ready,
    output logic                  rsp_valid,
    output logic [EBC_DATA_W-1:0] rsp_rdata,
    input  logic [EBC_DATA_W-1:0] gpio_out,
    input  logic [EBC_DATA_W-1:0] gpio_oe,
    input  logic [EBC_DATA_W-1:0] ad_in,
    output logic [EBC_DATA_W-1:0] ad_out,
    output logic [EBC_DATA_W-1:0] ad_oe,
    output logic [EBC_HI_W-1:0]   a_hi,
    output logic                  ale,
    output logic                  rd_n,
    output logic                  wr_n,
    output logic                  wrl_n,
    output logic                  wrh_n,
    output logic                  bhe_n,
    output logic                  inst,
    input  logic                  hold_n,
    output logic                  hlda_n,
    output logic                  breq_n
);
    ebc_phase_e phase;
    ebc_req_t   cur_req;
    ebc_req_t   new_req;
    logic       held;
    logic       bus_idle;
    logic       start;

    // Gather the request fields and qualify acceptance.
    always_comb begin
        new_req.write = req_write;
        new_req.fetch = req_fetch;
        new_req.be    = req_be;
        new_req.addr  = req_addr;
        new_req.wdata = req_wdata;
        bus_idle      = (phase == PH_IDLE);
        req_ready     = bus_idle && !held && hold_n;
        start         = req_ready && req_valid;
        rsp_valid     = (phase == PH_RECOV);
    end

    ebc_cycle_fsm #(.WS_W(WS_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .req_in(new_req),
        .ws_count(ws_count), .ready(ready), .ad_in(ad_in),
        .phase(phase), .cur_req(cur_req), .rdata(rsp_rdata)
    );

    ebc_hold_arb u_arb (
        .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .hold_n(hold_n),
        .req_valid(req_valid), .held(held), .hlda_n(hlda_n), .breq_n(breq_n)
    );

    ebc_pad_mux u_pads (
        .clk(clk), .rst_n(rst_n), .phase(phase), .held(held), .cur_req(cur_req),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .ad_out(ad_out), .ad_oe(ad_oe),
        .a_hi(a_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .wrl_n(wrl_n),
        .wrh_n(wrh_n), .bhe_n(bhe_n), .inst(inst)
    );

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R12
    no_accept_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hlda_n |-> !req_ready);
endmodule

// File: tb/ext_bus_ctrl_test.sv
module ext_bus_ctrl_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_write = 0, req_fetch = 0;
    logic [1:0]  req_be = 2'b11;
    logic [20:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  ws_count = '0;
    logic        ready = 1;
    logic [15:0] gpio_out = 16'h5AC3, gpio_oe = 16'h0F0F, ad_in = '0;
    logic        hold_n = 1;
    logic        req_ready, rsp_valid, ale, rd_n, wr_n, wrl_n, wrh_n, bhe_n, inst;
    logic        hlda_n, breq_n;
    logic [15:0] rsp_rdata, ad_out, ad_oe;
    logic [4:0]  a_hi;
    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ext_bus_ctrl uut (.*);

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_wrl(bit wr, logic [1:0] be);
        return !(wr && be[0]);
    endfunction
    function automatic logic exp_wrh(bit wr, logic [1:0] be);
        return !(wr && be[1]);
    endfunction
    function automatic int strobe_len(int ws, int nr);
        return ((ws > nr) ? ws : nr) + 1;
    endfunction

    task automatic check_idle(input string tag);
        chk(tag, "ad_out", ad_out, gpio_out);
        chk(tag, "ad_oe", ad_oe, gpio_oe);
        chk(tag, "ale", ale, 0);
        chk(tag, "strobes", {rd_n, wr_n, wrl_n, wrh_n, bhe_n}, 5'b11111);
        chk(tag, "rsp_valid", rsp_valid, 0);
    endtask

    task automatic run_cycle(input bit wr, input bit fe, input logic [1:0] be,
                             input logic [20:0] addr, input logic [15:0] wd,
                             input logic [15:0] rd, input int ws, input int nr,
                             input bit hold_mid);
        int len;
        len = strobe_len(ws, nr);
        @(negedge clk);
        ws_count = ws[3:0]; req_write = wr; req_fetch = fe; req_be = be;
        req_addr = addr; req_wdata = wd; req_valid = 1; ready = 1;
        #1 chk("R2", "req_ready idle", req_ready, 1);
        @(negedge clk);
        req_valid = 0;
        #1;
        chk("R2", "ale", ale, 1);
        chk("R2", "ad_out addr", ad_out, addr[15:0]);
        chk("R2", "ad_oe addr", ad_oe, 16'hFFFF);
        chk("R2", "a_hi", a_hi, addr[20:16]);
        chk("R2", "rd/wr in addr", {rd_n, wr_n}, 2'b11);
        chk("R6", "bhe_n addr", bhe_n, !be[1]);
        chk("R7", "inst addr", inst, fe);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            ready = (i >= nr);
            ad_in = (i == len - 1) ? rd : ~rd;
            if (hold_mid && i == 0) hold_n = 0;
            #1;
            chk(nr > ws ? "R4" : "R3", "rd_n strobe", rd_n, wr);
            chk("R3", "wr_n strobe", wr_n, !wr);
            chk("R5", "wrl_n", wrl_n, exp_wrl(wr, be));
            chk("R5", "wrh_n", wrh_n, exp_wrh(wr, be));
            chk("R6", "bhe_n strobe", bhe_n, !be[1]);
            chk("R7", "inst strobe", inst, fe);
            chk(wr ? "R9" : "R8", "ad_oe strobe", ad_oe, wr ? 16'hFFFF : 16'h0000);
            if (wr) chk("R9", "ad_out data", ad_out, wd);
            chk("R11", "hlda_n during cycle", hlda_n, 1);
        end
        @(negedge clk);
        ready = 1;
        #1;
        chk(nr > ws ? "R4" : "R3", "rsp_valid after strobe", rsp_valid, 1);
        chk("R10", "strobes recov", {rd_n, wr_n, wrl_n, wrh_n}, 4'b1111);
        chk("R10", "ad_oe recov", ad_oe, 16'h0000);
        chk("R7", "inst recov", inst, fe);
        chk("R11", "hlda_n recov", hlda_n, 1);
        if (!wr) chk("R8", "rsp_rdata", rsp_rdata, rd);
        @(negedge clk);
        #1;
        check_idle("R10");
        chk("R7", "inst idle", inst, 0);
    endtask

    initial begin
        void'($urandom(32'd7781));
        repeat (3) @(negedge clk);
        #1 check_idle("R1");
        chk("R1", "hlda_n reset", hlda_n, 1);
        @(negedge clk); rst_n = 1;
        #1 check_idle("R1");

        run_cycle(0, 1, 2'b11, 21'h1ABCDE, 16'h0, 16'hBEEF, 0, 0, 0);
        run_cycle(1, 0, 2'b01, 21'h012345, 16'hA55A, 16'h0, 2, 0, 0);
        run_cycle(1, 0, 2'b10, 21'h1FFFFF, 16'h1234, 16'h0, 0, 3, 0);
        run_cycle(0, 0, 2'b10, 21'h000001, 16'h0, 16'hC001, 3, 1, 0);
        run_cycle(0, 0, 2'b01, 21'h100000, 16'h0, 16'h7E57, 1, 4, 0);

        // Hold raised mid-cycle: granted only after the cycle ends.
        run_cycle(0, 0, 2'b11, 21'h0ABCD0, 16'h0, 16'h9999, 2, 0, 1);
        @(negedge clk);
        #1;
        chk("R11", "hlda_n granted", hlda_n, 0);
        chk("R11", "ad_oe held", ad_oe, 16'h0000);
        chk("R12", "breq_n no req", breq_n, 1);
        req_write = 1; req_be = 2'b11; req_addr = 21'h3; req_valid = 1;
        #1;
        chk("R12", "breq_n pending", breq_n, 0);
        chk("R12", "req_ready held", req_ready, 0);
        @(negedge clk);
        #1;
        chk("R12", "no cycle while held", ale, 0);
        chk("R12", "breq_n still", breq_n, 0);
        req_valid = 0; hold_n = 1;
        #1 chk("R12", "breq_n dropped", breq_n, 1);
        chk("R13", "hlda_n before edge", hlda_n, 0);
        @(negedge clk);
        #1;
        chk("R13", "hlda_n released", hlda_n, 1);
        chk("R13", "req_ready again", req_ready, 1);
        check_idle("R1");
        run_cycle(1, 0, 2'b11, 21'h055555, 16'hFACE, 16'h0, 1, 0, 0);

        // Hold raised while idle: granted at the next edge.
        @(negedge clk);
        hold_n = 0;
        #1 chk("R11", "hlda_n not yet", hlda_n, 1);
        chk("R2", "req_ready hold low", req_ready, 0);
        @(negedge clk);
        #1 chk("R11", "hlda_n idle grant", hlda_n, 0);
        hold_n = 1;
        @(negedge clk);
        #1 chk("R13", "hlda_n idle release", hlda_n, 1);

        for (int k = 0; k < 40; k++) begin
            bit wr, fe;
            logic [1:0] be;
            wr = $urandom_range(0, 1);
            fe = !wr && $urandom_range(0, 1);
            be = 2'($urandom_range(1, 3));
            run_cycle(wr, fe, be, 21'($urandom), 16'($urandom), 16'($urandom),
                      $urandom_range(0, 3), $urandom_range(0, 4), 0);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule